// File: doc/BRIEF.md
# Supply Voltage Detector Controller

This block is the digital side of a supply voltage detector. Software sees one 4-bit control register on a small CPU bus. Bit 0 of that register switches an external analog comparator on and off through `cmp_en_o`. Bit 1 is a read-only latch that holds the comparator's low-supply verdict. A 1 in that bit means the supply was below the criteria voltage, and a 0 means it was at or above it.

The verdict is not tracked live. The block loads it only when software clears the enable bit, and it keeps that value until the next enable-then-disable cycle. The comparator flag passes through a two-flop synchronizer first, and the capture uses the synchronized value.

An on-time counter measures how long the detector has been on. The limit is derived from the clock frequency and the required settle time, which defaults to 100 us at 125 MHz, or 12500 cycles. When the detector is disabled, the block records whether that limit was reached. A separate debug address reports both this recorded flag and a live "settled" indication, so software can tell whether the captured verdict can be trusted.

Top module: `svd_ctrl`

## Requirements
- R1: Writing the control address (0) copies `bus_wdata[0]` into the enable bit, and `cmp_en_o` equals the enable bit at all times. Control read data bit 0 returns the enable bit.
- R2: Control bit 1 is read-only. Writing any value into bits 3..1 of the control address never changes the result bit.
- R3: A control write with `bus_wdata[0]`=0 while the enable bit is 1 loads the synchronized comparator flag into the result bit (control read data bit 1). A result of 1 means the supply is below the criteria voltage, and 0 means it is at or above it.
- R4: The result bit changes at no other time. In particular it does not change while the detector runs, or when 0 is written while the enable bit is already 0.
- R5: After reset the enable bit, the result bit, the recorded settle flag, `bus_rdata` and `cmp_en_o` are all 0.
- R6: Control read data bits 3..2 always read 0. Reads of addresses other than 0 (control) and 1 (debug) return 0.
- R7: `bus_rdata` is registered. It shows the addressed register one cycle after the clock edge that samples `bus_re`=1, and it is 0 after any edge where `bus_re`=0.
- R8: The on-time counter restarts only when the enable bit goes 0 to 1. Writing 1 while the detector is already enabled does not restart it. The counter saturates at the settle limit L.
- R9: At the disabling write, debug bit 0 records whether the disabling edge came L or more cycles after the enabling edge. It reads 1 for exactly L cycles and 0 for L-1 cycles.
- R10: Debug bit 1 reads 1 when the detector is enabled and at least L cycles have passed since the enabling edge.
- R11: A comparator change is seen by the capture only after two clock edges. A disable written on the edge right after a change captures the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 is control, 1 is debug |
| bus_wdata | input | 4 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 4 | Registered read data |
| cmp_low_i | input | 1 | Comparator flag: 1 means the supply is below the criteria voltage (asynchronous) |
| cmp_en_o | output | 1 | Comparator enable |

## Verification
A wrong enable bit shows on `cmp_en_o` in the cycle after the write, and on the next control read. A corrupted result latch or settle flag stays hidden until software reads it, so each disable is followed at once by reads of the control and debug addresses. An on-time counter that is off by one is visible only at the settle boundary. The bench therefore disables after exactly L and exactly L-1 cycles, and also re-writes 1 in the middle of a run to expose a wrong restart.

// File: rtl/svd_pkg.sv
// Package: shared constants and types for the supply voltage detector controller.
// Assumes a 4-bit register width; bit positions are decoded by software.
package svd_pkg;
    localparam int REG_W   = 4;
    localparam int EN_BIT  = 0;
    localparam int RES_BIT = 1;

    // Read selector produced by the address decoder.
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_CTRL = 2'd1,
        RD_DBG  = 2'd2
    } rd_sel_t;

    // Settle limit in clock cycles from clock rate and microseconds, at least 1.
    function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                  input int unsigned settle_us);
        int unsigned c;
        c = (clk_hz / 1_000_000) * settle_us;
        return (c == 0) ? 1 : c;
    endfunction
endpackage

// File: rtl/svd_sync.sv
// Module: multi-stage synchronizer for the asynchronous comparator flag.
// Assumes STAGES >= 2; output reflects input STAGES edges later; resets to 0.
module svd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/svd_decode.sv
// Module: bus address/strobe decoder.
// Produces the control write qualifier, enable start/stop pulses and read select.
// Assumes single-cycle strobes; the current enable bit is fed back from the registers.
module svd_decode
    import svd_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int DBG_ADDR  = 1
) (
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en_bit,
    input  logic              en_q,
    output logic              wr_ctrl,
    output logic              start_pulse,
    output logic              stop_pulse,
    output rd_sel_t           rd_sel
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] DBG_A  = ADDR_W'(DBG_ADDR);

    // Decode write qualifiers and enable edges.
    always_comb begin
        wr_ctrl     = bus_we && (bus_addr == CTRL_A);
        start_pulse = wr_ctrl &&  wr_en_bit && !en_q;
        stop_pulse  = wr_ctrl && !wr_en_bit &&  en_q;
    end

    // Decode the read target; unmatched addresses select nothing.
    always_comb begin
        if (!bus_re)                rd_sel = RD_NONE;
        else if (bus_addr == CTRL_A) rd_sel = RD_CTRL;
        else if (bus_addr == DBG_A)  rd_sel = RD_DBG;
        else                         rd_sel = RD_NONE;
    end
endmodule

// File: rtl/svd_ontime.sv
// Module: saturating on-time counter.
// Loads 1 on the enabling edge (that cycle counts), counts up while running,
// saturates at LIMIT and holds while stopped. settled_o is high at saturation.
module svd_ontime #(
    parameter int unsigned LIMIT = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic settled_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Restart on enable, count while running, stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (start_i)                    cnt_q <= ONE_V;
        else if (run_i && cnt_q != LIMIT_V)  cnt_q <= cnt_q + ONE_V;
    end

    assign settled_o = (cnt_q == LIMIT_V);

    // R8: the count never passes the limit.
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT_V);
    // R8: an enabling edge restarts the count at one.
    p_cnt_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> cnt_q == ONE_V);
    // R8: a running, unsaturated count advances by exactly one.
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && cnt_q != LIMIT_V) |=> cnt_q == $past(cnt_q) + ONE_V);
    // R8: a stopped counter holds its value.
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/svd_regs.sv
// Module: enable bit, result latch, recorded settle flag and registered read port.
// Assumes the decoder gives one-cycle pulses; the capture uses the synchronized flag.
module svd_regs
    import svd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wr_data,
    input  logic             stop_pulse,
    input  logic             cmp_sync,
    input  logic             cnt_settled,
    input  rd_sel_t          rd_sel,
    output logic             en_q,
    output logic [REG_W-1:0] rdata_q
);
    logic res_q;
    logic cap_settled_q;
    logic live_settled;
    logic [REG_W-1:0] rd_mux;

    // Enable bit follows every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (wr_ctrl) en_q <= wr_data[EN_BIT];
    end

    // Result and settle flag are loaded only on the disabling write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q         <= 1'b0;
            cap_settled_q <= 1'b0;
        end else if (stop_pulse) begin
            res_q         <= cmp_sync;
            cap_settled_q <= cnt_settled;
        end
    end

    assign live_settled = en_q && cnt_settled;

    // Select the addressed register; unused bits read zero.
    always_comb begin
        rd_mux = '0;
        case (rd_sel)
            RD_CTRL: begin
                rd_mux[EN_BIT]  = en_q;
                rd_mux[RES_BIT] = res_q;
            end
            RD_DBG: begin
                rd_mux[0] = cap_settled_q;
                rd_mux[1] = live_settled;
            end
            default: rd_mux = '0;
        endcase
    end

    // Register read data; zero when no read is taking place.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_mux;
    end

    // R1: a control write sets the enable bit to the written bit 0.
    p_en_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> en_q == $past(wr_data[EN_BIT]));
    // R1: the enable bit holds without a control write.
    p_en_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(en_q));
    // R3: the disabling write loads the synchronized flag.
    p_res_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> res_q == $past(cmp_sync));
    // R4: the result changes only on a disabling write.
    p_res_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_pulse |=> $stable(res_q));
    // R2: writing the upper bits without disabling leaves the result alone.
    p_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !stop_pulse && (wr_data[RES_BIT] || (|wr_data[REG_W-1:2])))
        |=> $stable(res_q));
    // R9: the recorded settle flag matches the counter at the disabling write.
    p_settle_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> cap_settled_q == $past(cnt_settled));
    // R6: the upper read bits are always zero.
    p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_q[REG_W-1:2] == '0);
    // R7: without a selected read the next read data is zero.
    p_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == RD_NONE) |=> rdata_q == '0);
endmodule

// File: rtl/svd_ctrl.sv
// Module: supply voltage detector controller top.
// One control register (enable, result) and one debug register (settle flags).
// Assumes a single clock, synchronous active-low reset and an asynchronous
// comparator flag; the enable output drives the comparator directly.
module svd_ctrl
    import svd_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned SETTLE_US   = 100,
    parameter int          ADDR_W      = 2,
    parameter int          CTRL_ADDR   = 0,
    parameter int          DBG_ADDR    = 1,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              cmp_low_i,
    output logic              cmp_en_o
);
    localparam int unsigned LIMIT = settle_cycles(CLK_HZ, SETTLE_US);

    logic    en_q;
    logic    wr_ctrl;
    logic    start_pulse;
    logic    stop_pulse;
    logic    cmp_sync;
    logic    cnt_settled;
    rd_sel_t rd_sel;

    svd_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .DBG_ADDR  (DBG_ADDR)
    ) u_decode (
        .bus_we      (bus_we),
        .bus_re      (bus_re),
        .bus_addr    (bus_addr),
        .wr_en_bit   (bus_wdata[EN_BIT]),
        .en_q        (en_q),
        .wr_ctrl     (wr_ctrl),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .rd_sel      (rd_sel)
    );

    svd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_low_i),
        .q_o   (cmp_sync)
    );

    svd_ontime #(.LIMIT(LIMIT)) u_ontime (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_pulse),
        .run_i     (en_q),
        .settled_o (cnt_settled)
    );

    svd_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wr_data     (bus_wdata),
        .stop_pulse  (stop_pulse),
        .cmp_sync    (cmp_sync),
        .cnt_settled (cnt_settled),
        .rd_sel      (rd_sel),
        .en_q        (en_q),
        .rdata_q     (bus_rdata)
    );

    assign cmp_en_o = en_q;

    // R1: the comparator is enabled one edge after an enabling write.
    p_cmp_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(CTRL_ADDR) && bus_wdata[EN_BIT]) |=> cmp_en_o);
endmodule

// File: tb/svd_ctrl_test.sv
// Scoreboard bench: read tasks queue expected values; a monitor compares results.
module svd_ctrl_test;
    localparam int L = 12500; // 125 MHz * 100 us

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [3:0] bus_rdata;
    logic       cmp_low_i = 1'b0;
    logic       cmp_en_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];
    logic  re_seen = 1'b0;

    svd_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .cmp_low_i (cmp_low_i),
        .cmp_en_o  (cmp_en_o)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: note reads at the edge, compare at the following falling edge.
    always @(posedge clk) re_seen <= bus_re;
    always @(negedge clk) begin
        if (re_seen) begin
            if (sbq.size() == 0) begin
                check(bus_rdata, 4'hx, "R7 unexpected read data");
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(bus_rdata, it.exp, it.tag);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [3:0] exp, input string tag);
        bus_addr = a; bus_re = 1'b1;
        sbq.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R5: reset state
        check({3'b0, cmp_en_o}, 4'b0000, "R5 cmp_en after reset");
        check(bus_rdata, 4'b0000, "R5 rdata after reset");
        rd(2'd0, 4'b0000, "R5 control after reset");
        rd(2'd1, 4'b0000, "R5 debug after reset");
        check(bus_rdata, 4'b0000, "R7 idle rdata after read");

        // Sequence A: supply low, settled run of exactly L cycles.
        cmp_low_i = 1'b1;
        wr(2'd0, 4'b0001);                      // enable edge k
        check({3'b0, cmp_en_o}, 4'b0001, "R1 cmp_en on");
        idle(L - 2);
        rd(2'd0, 4'b0001, "R4 result stays 0 while running"); // edge k+L-1
        wr(2'd0, 4'b0000);                      // disable edge k+L
        check({3'b0, cmp_en_o}, 4'b0000, "R1 cmp_en off");
        rd(2'd0, 4'b0010, "R3 low supply captured");
        rd(2'd1, 4'b0001, "R9 settled at exactly L");

        // R4/R2: writes while off do not reload or touch the result.
        cmp_low_i = 1'b0;
        idle(4);
        wr(2'd0, 4'b0000);
        rd(2'd0, 4'b0010, "R4 write 0 while off keeps result");
        wr(2'd0, 4'b1110);
        rd(2'd0, 4'b0010, "R2 upper-bit write ignored");
        rd(2'd3, 4'b0000, "R6 unmatched address reads 0");

        // Sequence B: good supply, one cycle short of the limit.
        wr(2'd0, 4'b0001);                      // edge k
        wr(2'd0, 4'b0011);                      // edge k+1, result bit write
        rd(2'd0, 4'b0011, "R2 write of bit1 ignored while on");
        rd(2'd1, 4'b0001, "R10 not yet settled live");
        idle(L - 5);
        wr(2'd0, 4'b0000);                      // edge k+L-1
        rd(2'd0, 4'b0000, "R3 normal supply captured");
        rd(2'd1, 4'b0000, "R9 not settled at L-1");

        // Sequence C: re-writing 1 mid-run does not restart the counter.
        wr(2'd0, 4'b0001);                      // edge k
        idle(L / 2 - 1);
        wr(2'd0, 4'b0001);                      // edge k+L/2
        idle(L - L / 2 - 1);
        rd(2'd1, 4'b0010, "R10 live settled after L / R8 no restart"); // edge k+L
        wr(2'd0, 4'b0000);
        rd(2'd1, 4'b0001, "R8 rewrite of 1 kept count");

        // Sequence D: synchronizer latency.
        cmp_low_i = 1'b0;
        wr(2'd0, 4'b0001);
        idle(8);
        cmp_low_i = 1'b1;
        wr(2'd0, 4'b0000);                      // one edge after change
        rd(2'd0, 4'b0000, "R11 change one edge before disable not seen");
        wr(2'd0, 4'b0001);
        idle(8);
        cmp_low_i = 1'b0;
        idle(1);
        wr(2'd0, 4'b0000);                      // second edge after change
        rd(2'd0, 4'b0010, "R11 old value captured at second edge");
        wr(2'd0, 4'b0001);
        idle(8);
        wr(2'd0, 4'b0000);
        rd(2'd0, 4'b0000, "R3 new value captured after sync");

        idle(3);
        check(4'(sbq.size()), 4'd0, "R7 every read produced data");
        summary();
        $finish;
    end
endmodule